// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is the target-side logic of a byte-wide serial EEPROM sitting on an I2C bus. It watches already-synchronized SCL and SDA samples on the system clock and pulls SDA low through an open-drain enable. It recognizes START and STOP conditions, compares the device-address byte with a fixed family code and a chip-select strap, and answers three kinds of read: a read that starts from the address counter left by the previous transfer, a selective read in which a write-addressed header loads a new word address before a repeated START, and a sequential read in which every acknowledged byte is followed by the next one.

The byte array is internal and holds 2^ADDR_BITS bytes. It is filled before bus traffic through a small valid/ready load port. The port applies back-pressure: `ld_ready_o` is high only while the bus side is idle (after reset, after a STOP or after a rejected header), and it drops on the cycle after any START. A byte offered while `ld_ready_o` is low is not taken and has no effect. The address counter is kept across transfers and rolls over from the top byte to byte 0.

Top module: `i2crd_target`

## Requirements
- R1: A START (SDA falling while SCL is high) in any phase restarts reception of a device-address byte and releases SDA; a STOP (SDA rising while SCL is high) releases SDA and returns the block to idle.
- R2: The device-address byte is sent MSB first with bits [7:4] = 4'b1010, bits [3:2] = `chip_sel_i`, bit [1] = word-address bit 16 and bit [0] = R/W (1 = read); on a match the block holds SDA low for the whole ninth SCL clock.
- R3: A device-address byte that does not match is not acknowledged, and the bus is ignored until the next START.
- R4: After a write-addressed header, two word-address bytes (high byte first) are each acknowledged, and the counter is loaded from them (bit 16 from the header) when the low byte is taken; no memory location changes.
- R5: After an acknowledged read header, the byte at the counter is shifted out MSB first, and SDA is only ever pulled low while SCL is low.
- R6: A master acknowledge (SDA low in the ninth clock) makes the block send the next byte; a NoACK makes it release SDA and send nothing more until a START.
- R7: The counter advances by one after each byte sent and keeps its value between transfers, so a read without a word address continues after the last byte read.
- R8: After byte 2^ADDR_BITS-1 is sent, the counter wraps to byte 0.
- R9: Data bytes that follow the word address of a write are not acknowledged and do not alter memory.
- R10: `ld_ready_o` is high only while idle; a byte with `ld_valid_i` and `ld_ready_o` both high is written to `ld_addr_i`, and a byte offered while `ld_ready_o` is low leaves memory unchanged.
- R11: After reset SDA is released, `ld_ready_o` is high and the counter points at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| chip_sel_i | input | 2 | Strap compared with device-address bits [3:2] |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ld_valid_i | input | 1 | Preload byte offered |
| ld_ready_o | output | 1 | Preload byte can be taken (bus idle) |
| ld_addr_i | input | ADDR_BITS | Preload byte address |
| ld_data_i | input | 8 | Preload byte value |

## Verification
The bound checker watches on every cycle that SDA is only ever pulled low while SCL is low, that START closes the load port and STOP releases SDA and reopens it, that the counter holds still while idle, and that a byte sent from the top location rolls the counter to zero. Whether the right bytes come out in the right order, whether headers are matched or refused, that a dummy write loads the counter without storing data, and that a refused preload leaves memory intact can only be shown by the bench's read sequences, which compare every received byte and acknowledge bit with a model of memory and counter.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WHI, PH_WLO, PH_ACK, PH_SEND, PH_MACK, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    AF_READ, AF_HI, AF_LO, AF_DONE
  } after_t;
endpackage

// File: rtl/i2crd_line_events.sv
module i2crd_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  assign bus_start = scl_q && scl_i && sda_q && !sda_i;
  assign bus_stop  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2crd_byte_store.sv
module i2crd_byte_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2crd_target.sv
module i2crd_target
  import i2crd_pkg::*;
#(
  parameter int ADDR_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [1:0]           chip_sel_i,
  output logic                 sda_oe_o,
  input  logic                 ld_valid_i,
  output logic                 ld_ready_o,
  input  logic [ADDR_BITS-1:0] ld_addr_i,
  input  logic [7:0]           ld_data_i
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);

  logic scl_rise, scl_fall, ev_start, ev_stop;
  phase_t ph_q;
  after_t af_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [7:0]           sh_q, hi_q, tx_q;
  logic                 a16_q, mack_q, oe_q;
  logic [ADDR_BITS-1:0] ptr_q;
  logic [7:0]           rd_data;
  logic                 byte_done, hdr_match;

  i2crd_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  i2crd_byte_store #(.AW(ADDR_BITS), .DW(8)) u_store (
    .clk(clk), .we(ld_valid_i && ld_ready_o), .waddr(ld_addr_i),
    .wdata(ld_data_i), .raddr(ptr_q), .rdata(rd_data)
  );

  assign ld_ready_o = (ph_q == PH_IDLE);
  assign sda_oe_o   = oe_q;
  assign byte_done  = (ph_q == PH_SEND) && scl_fall && (cnt_q == LAST_BIT);
  assign hdr_match  = (sh_q[7:4] == DEV_CODE) && (sh_q[3:2] == chip_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      af_q   <= AF_DONE;
      cnt_q  <= '0;
      sh_q   <= '0;
      hi_q   <= '0;
      tx_q   <= '0;
      a16_q  <= 1'b0;
      mack_q <= 1'b1;
      oe_q   <= 1'b0;
      ptr_q  <= '0;
    end else if (ev_start) begin
      ph_q  <= PH_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (ev_stop) begin
      ph_q <= PH_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_DEV, PH_WHI, PH_WLO: begin
          if (scl_rise && cnt_q != BYTE_BITS) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            cnt_q <= '0;
            if (ph_q == PH_DEV) begin
              if (hdr_match) begin
                oe_q  <= 1'b1;
                ph_q  <= PH_ACK;
                a16_q <= sh_q[1];
                af_q  <= sh_q[0] ? AF_READ : AF_HI;
              end else begin
                ph_q <= PH_IDLE;
              end
            end else if (ph_q == PH_WHI) begin
              hi_q <= sh_q;
              oe_q <= 1'b1;
              ph_q <= PH_ACK;
              af_q <= AF_LO;
            end else begin
              ptr_q <= ADDR_BITS'({a16_q, hi_q, sh_q});
              oe_q  <= 1'b1;
              ph_q  <= PH_ACK;
              af_q  <= AF_DONE;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            unique case (af_q)
              AF_READ: begin
                ph_q  <= PH_SEND;
                tx_q  <= rd_data;
                oe_q  <= !rd_data[7];
                cnt_q <= '0;
              end
              AF_HI:   begin ph_q <= PH_WHI;  oe_q <= 1'b0; end
              AF_LO:   begin ph_q <= PH_WLO;  oe_q <= 1'b0; end
              default: begin ph_q <= PH_SKIP; oe_q <= 1'b0; end
            endcase
          end
        end
        PH_SEND: begin
          if (byte_done) begin
            oe_q  <= 1'b0;
            ph_q  <= PH_MACK;
            ptr_q <= ptr_q + 1'b1;
          end else if (scl_fall) begin
            cnt_q <= cnt_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
            oe_q  <= !tx_q[6];
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_q <= sda_i;
          end else if (scl_fall) begin
            if (!mack_q) begin
              ph_q  <= PH_SEND;
              tx_q  <= rd_data;
              oe_q  <= !rd_data[7];
              cnt_q <= '0;
            end else begin
              ph_q <= PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2crd_checks.sv
module i2crd_checks #(
  parameter int ADDR_BITS = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_i,
  input logic                 sda_oe_o,
  input logic                 ld_ready_o,
  input logic                 ev_start,
  input logic                 ev_stop,
  input logic                 byte_done,
  input logic [ADDR_BITS-1:0] ptr_q
);
  assert_pull_only_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  assert_start_closes_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !ld_ready_o);

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_oe_o && ld_ready_o));

  assert_ptr_held_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready_o && !ev_start) |=> $stable(ptr_q));

  assert_ptr_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (ptr_q == '1)) |=> (ptr_q == '0));
endmodule

bind i2crd_target i2crd_checks #(.ADDR_BITS(ADDR_BITS)) u_checks (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .ld_ready_o(ld_ready_o), .ev_start(ev_start), .ev_stop(ev_stop),
  .byte_done(byte_done), .ptr_q(ptr_q)
);

// File: tb/test_i2crd_target.sv
module test_i2crd_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] CS = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, ld_valid = 1'b0, ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] exp_mem [DEPTH];
  int exp_ptr = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2crd_target #(.ADDR_BITS(AW)) i_i2crd_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .chip_sel_i(CS), .sda_oe_o(sda_oe), .ld_valid_i(ld_valid),
    .ld_ready_o(ld_ready), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  function automatic logic [7:0] hdr(input logic [1:0] cs, input logic a16, input logic rw);
    return {4'b1010, cs, a16, rw};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); ack = sda_line; scl = 1'b0; hp();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1'b1; hp(); b[i] = sda_line; scl = 1'b0;
    end
    sda_m = !give_ack; hp(); scl = 1'b1; hp(); scl = 1'b0; hp(); sda_m = 1'b1;
  endtask

  task automatic read_run(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, b, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
  endtask

  task automatic immediate_read(input int n, input string req);
    logic a;
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b1), a);
    chk("R2 read header ack", a, 0);
    read_run(n, req);
    bus_stop();
    chk("R1 SDA released after STOP", sda_oe, 0);
  endtask

  task automatic selective_read(input int addr, input int n, input string req);
    logic a;
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b0), a);
    chk("R2 write header ack", a, 0);
    send_byte(8'((addr >> 8) & 8'hFF), a);
    chk("R4 high address ack", a, 0);
    send_byte(8'(addr & 8'hFF), a);
    chk("R4 low address ack", a, 0);
    exp_ptr = addr % DEPTH;
    immediate_read(n, req);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int unsigned seed_v;
    int low_seen;
    seed_v = $urandom(32'h5EED_1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 SDA released at reset", sda_oe, 0);
    chk("R11 load ready at reset", ld_ready, 1);

    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = 8'($urandom);
      ld_valid = 1'b1; ld_addr = AW'(i); ld_data = exp_mem[i];
      @(negedge clk);
    end
    ld_valid = 1'b0;

    immediate_read(2, "R11 counter starts at zero");
    selective_read(8'h37, 3, "R5 R6 selective sequential");
    immediate_read(2, "R7 continues after last read");
    selective_read(DEPTH - 2, 4, "R8 wrap through top byte");
    chk("R8 counter after wrap", exp_ptr, 2);
    immediate_read(1, "R8 R7 read after wrap");

    // R3: wrong chip select refused and the rest ignored
    bus_start();
    send_byte(hdr(~CS, 1'b0, 1'b1), a);
    chk("R3 mismatched header not acked", a, 1);
    send_byte(8'h00, a);
    chk("R3 bus ignored after mismatch", a, 1);
    bus_stop();
    immediate_read(2, "R3 R7 counter untouched by mismatch");

    // R9: data after a word address
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b0), a);
    send_byte(8'h00, a);
    send_byte(8'h80, a);
    send_byte(~exp_mem[8'h80], a);
    chk("R9 data byte not acked", a, 1);
    bus_stop();
    exp_ptr = 8'h80;
    immediate_read(1, "R9 memory unchanged after data byte");

    // R6: after NoACK the line stays free
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b1), a);
    recv_byte(1'b0, b);
    chk("R6 byte before NoACK", b, exp_mem[exp_ptr]);
    exp_ptr = (exp_ptr + 1) % DEPTH;
    low_seen = 0;
    for (int i = 0; i < 9; i++) begin
      hp(); scl = 1'b1; hp(); if (sda_line == 1'b0) low_seen++; scl = 1'b0;
    end
    chk("R6 no data after NoACK", low_seen, 0);
    bus_stop();

    // R10: preload offered mid-transfer is refused
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b1), a);
    chk("R10 ready low during transfer", ld_ready, 0);
    ld_valid = 1'b1; ld_addr = AW'(exp_ptr); ld_data = ~exp_mem[exp_ptr];
    @(negedge clk);
    ld_valid = 1'b0;
    read_run(1, "R10 refused load leaves memory");
    bus_stop();
    chk("R10 ready back after STOP", ld_ready, 1);

    // R1: START in the middle of a word address restarts header reception
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b0), a);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    bus_start();
    send_byte(hdr(CS, 1'b0, 1'b1), a);
    chk("R1 header after restarting START", a, 0);
    read_run(1, "R1 read after restart");
    bus_stop();

    for (int it = 0; it < 25; it++) begin
      int n = 1 + int'($urandom % 5);
      int ad = ($urandom % 4 == 0) ? DEPTH - 1 - int'($urandom % 3) : int'($urandom % DEPTH);
      if ($urandom % 2 == 0) selective_read(ad, n, "R5 R8 random selective");
      else immediate_read(n, "R7 random immediate");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule